// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver with Error Tagging

This block recovers asynchronous serial frames from one input line. A separate baud generator supplies a one-clock enable pulse at sixteen times the bit rate. The line first passes through a two-flop synchroniser. When the line falls after an idle-high period, the receiver starts a frame. It takes three samples near the centre of each bit period and uses their majority as the bit value. The data bits are collected least significant bit first. The receiver then checks the optional parity bit and the first stop bit.

Each frame yields one entry on a write port: a single-cycle valid strobe and an 11-bit word. The word holds the data byte and three error flags. Runtime inputs select the data length (5 to 8 bits), whether parity is present, even or odd parity, and an optional transition-code mode. In that mode a change of line level between bit periods reads as one, and a steady level reads as zero. The storage behind the write port is not part of this block, and neither are the rate generator and the interrupt logic.

Top module: `uart_rx_tagger`

## Requirements
- R1: While idle and armed, a tick that sees the synchronised line low starts a frame; that tick counts as tick 0 of the start bit. The receiver is armed only after it has seen the line high on a tick.
- R2: Every bit is sampled on ticks 7, 8 and 9 of its 16-tick period, and its value is the majority of the three samples, so a wrong level on any one of those ticks has no effect on the entry.
- R3: If the start bit's majority is high, the receiver returns to idle and writes no entry.
- R4: cfg_dlen selects 5 + cfg_dlen data bits (0 gives 5, 3 gives 8). Bits arrive least significant first into out_data[7:0], and the unused upper bits are zero.
- R5: When cfg_par_en is 1, one parity bit follows the data. The expected value is the XOR of the data bits with even parity (cfg_par_odd = 0) and its inverse with odd parity (cfg_par_odd = 1). A mismatch sets out_data[8]. With parity disabled, out_data[8] is 0.
- R6: out_data[9] (framing error) is set when the majority vote on the first stop bit is low.
- R7: out_data[10] (break) is set when the raw voted levels of every data bit, the parity bit if present, and the stop bit are all low.
- R8: With cfg_tdec = 1, each data and parity bit decodes as its voted level XOR the voted level of the bit period before it. The first data bit is compared with the start bit (low). Parity is checked on the decoded bits. Start and stop bits are always read as raw levels.
- R9: Each accepted frame gives exactly one out_valid pulse, one clock wide. It is raised in the clock after the tick that carries the stop bit's ninth sample.
- R10: Only the first stop bit is examined. If it votes high, the receiver is armed at once, so a start bit that directly follows one stop bit is caught. If it votes low, a line held low afterwards starts no new frame until the line has been seen high.
- R11: During and directly after reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| tick16 | input | 1 | One-clock enable at 16x the bit rate |
| cfg_dlen | input | 2 | Data length select, 5 + value bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_tdec | input | 1 | Enables transition-code decoding |
| out_valid | output | 1 | Entry write strobe |
| out_data | output | 11 | {break, framing error, parity error, data[7:0]} |

## Verification
The assertions assume that tick16 is a one-clock pulse and that pulses are far enough apart for a line change to cross the synchroniser before the next tick. They also assume that the configuration inputs hold steady from a start bit until its entry has been written, since the checks on data width and the parity flag read the live configuration. The stimulus drives everything on falling edges, with a tick every fourth clock. The line changes only at the start of a tick slot, and the configuration is set only while the line idles between frames. Single-tick corruptions and truncated start pulses are placed deliberately, on ticks the requirements say must be voted out or rejected.

// File: rtl/urx_pkg.sv
package urx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  // two-of-three vote
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= d_async;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/urx_sampler.sv
module urx_sampler
  import urx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic run,
  input  logic go,
  output logic mid_stb,
  output logic vote
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  logic [CW-1:0] cnt;
  logic          smp_early;
  logic          smp_centre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      smp_early  <= 1'b1;
      smp_centre <= 1'b1;
    end else begin
      if (go) cnt <= CW'(1);
      else if (run && tick) cnt <= (cnt == CW'(OSR-1)) ? '0 : cnt + 1'b1;
      if (run && tick && cnt == CW'(MID-1)) smp_early  <= line;
      if (run && tick && cnt == CW'(MID))   smp_centre <= line;
    end
  end

  // third sample is taken live on the deciding tick
  assign mid_stb = run && tick && (cnt == CW'(MID+1));
  assign vote    = maj3(smp_early, smp_centre, line);
endmodule

// File: rtl/urx_tdecode.sv
module urx_tdecode (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ref_load,
  input  logic bit_stb,
  input  logic raw,
  output logic dec
);
  logic prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prev_lvl <= 1'b0;
    else if (ref_load) prev_lvl <= 1'b0;   // accepted start bit is low
    else if (bit_stb)  prev_lvl <= raw;
  end

  assign dec = enable ? (raw ^ prev_lvl) : raw;
endmodule

// File: rtl/uart_rx_tagger.sv
module uart_rx_tagger
  import urx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MIN_LEN     = 5,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = $clog2(DATA_W - MIN_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic              tick16,
  input  logic [LEN_W-1:0]  cfg_dlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_tdec,
  output logic              out_valid,
  output logic [DATA_W+2:0] out_data
);
  localparam int IDX_W = $clog2(DATA_W);

  function automatic logic expect_par(input logic [DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  function automatic logic [IDX_W-1:0] last_index(input logic [LEN_W-1:0] sel);
    return IDX_W'(MIN_LEN - 1) + IDX_W'(sel);
  endfunction

  rx_state_e         state;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              par_rx;
  logic              any_one;
  logic              armed;

  // named events
  logic line_s, busy, start_go, mid_stb, vote, dbit;
  logic false_start, stop_mid, bit_stb, ref_load;

  urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(rx_in), .q_sync(line_s)
  );

  assign busy     = (state != ST_IDLE);
  assign start_go = !busy && tick16 && !line_s && armed;

  urx_sampler #(.OSR(OSR)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s),
    .run(busy), .go(start_go), .mid_stb(mid_stb), .vote(vote)
  );

  assign false_start = mid_stb && (state == ST_START) && vote;
  assign ref_load    = mid_stb && (state == ST_START) && !vote;
  assign bit_stb     = mid_stb && ((state == ST_DATA) || (state == ST_PAR));
  assign stop_mid    = mid_stb && (state == ST_STOP);

  urx_tdecode u_tdec (
    .clk(clk), .rst_n(rst_n), .enable(cfg_tdec), .ref_load(ref_load),
    .bit_stb(bit_stb), .raw(vote), .dec(dbit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      shreg     <= '0;
      par_rx    <= 1'b0;
      any_one   <= 1'b0;
      armed     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (tick16) begin
            if (line_s) armed <= 1'b1;
            else if (armed) begin
              armed <= 1'b0;
              state <= ST_START;
            end
          end
        end
        ST_START: begin
          if (mid_stb) begin
            if (vote) state <= ST_IDLE;
            else begin
              state   <= ST_DATA;
              idx     <= '0;
              shreg   <= '0;
              any_one <= 1'b0;
            end
          end
        end
        ST_DATA: begin
          if (mid_stb) begin
            shreg[idx] <= dbit;
            any_one    <= any_one | vote;
            if (idx == last_index(cfg_dlen))
              state <= cfg_par_en ? ST_PAR : ST_STOP;
            else
              idx <= idx + 1'b1;
          end
        end
        ST_PAR: begin
          if (mid_stb) begin
            par_rx  <= dbit;
            any_one <= any_one | vote;
            state   <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (mid_stb) begin
            out_valid <= 1'b1;
            out_data  <= {(!any_one && !vote), !vote,
                          (cfg_par_en && (par_rx != expect_par(shreg, cfg_par_odd))),
                          shreg};
            armed     <= vote;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/urx_checker.sv
module urx_checker #(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_go,
  input logic              busy,
  input logic              false_start,
  input logic              stop_mid,
  input logic              out_valid,
  input logic [DATA_W+2:0] out_data,
  input logic              cfg_par_en,
  input logic [LEN_W-1:0]  cfg_dlen
);
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> busy);

  p_false_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |=> (!busy && !out_valid));

  p_short_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_dlen == '0) |-> (out_data[DATA_W-1:MIN_LEN] == '0));

  p_nopar_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cfg_par_en) |-> !out_data[DATA_W]);

  p_break_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data[DATA_W+2]) |-> (out_data[DATA_W+1] && out_data[DATA_W-1:0] == '0));

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(stop_mid));
endmodule

bind uart_rx_tagger urx_checker #(
  .DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_go(start_go), .busy(busy),
  .false_start(false_start), .stop_mid(stop_mid), .out_valid(out_valid),
  .out_data(out_data), .cfg_par_en(cfg_par_en), .cfg_dlen(cfg_dlen)
);

// File: tb/tb_uart_rx_tagger.sv
module tb_uart_rx_tagger;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1;
  logic tick16 = 1'b0;
  logic [1:0] cfg_dlen = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_tdec = 1'b0;
  logic out_valid;
  logic [10:0] out_data;

  int checks = 0, failures = 0, seen = 0;
  logic [10:0] exp_q[$];
  string tag_q[$];
  logic [10:0] mon_exp;
  string mon_tag;

  uart_rx_tagger dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick16(tick16),
    .cfg_dlen(cfg_dlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_tdec(cfg_tdec), .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one tick slot: line set, three quiet clocks, one tick clock
  task automatic send_tick(input logic lvl);
    rx_in = lvl;
    repeat (3) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  task automatic send_bit(input logic lvl, input int gl);
    for (int t = 0; t < 16; t++) send_tick((t == gl) ? ~lvl : lvl);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send_tick(1'b1);
  endtask

  // gbit: index in the frame (0 = start); gtick: corrupted tick in that bit
  task automatic send_frame(input logic [7:0] data, input logic [1:0] dl,
                            input bit pe, input bit po, input bit td,
                            input bit stop_lvl, input bit bad_par,
                            input int gbit, input int gtick, input string req);
    int n;
    int nb;
    logic [7:0] d;
    logic p;
    logic prev;
    bit any;
    logic lv [12];
    n = 5 + int'(dl);
    d = data & 8'((9'd1 << n) - 1);
    p = (^d) ^ po;
    if (bad_par) p = ~p;
    prev = 1'b0;
    any = 1'b0;
    cfg_dlen = dl; cfg_par_en = pe; cfg_par_odd = po; cfg_tdec = td;
    lv[0] = 1'b0;
    nb = 1;
    for (int i = 0; i < n; i++) begin
      lv[nb] = td ? (prev ^ d[i]) : d[i];
      prev = lv[nb];
      any |= lv[nb];
      nb++;
    end
    if (pe) begin
      lv[nb] = td ? (prev ^ p) : p;
      any |= lv[nb];
      nb++;
    end
    lv[nb] = stop_lvl;
    nb++;
    exp_q.push_back({(!any && !stop_lvl), !stop_lvl, (pe && bad_par), d});
    tag_q.push_back(req);
    for (int b = 0; b < nb; b++) send_bit(lv[b], (b == gbit) ? gtick : -1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      seen++;
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R10 unexpected entry actual=%0h expected=none", out_data);
      end else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        chk(out_data == mon_exp, mon_tag, "entry", 32'(out_data), 32'(mon_exp));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s;
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R11", "valid in reset", 32'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", "valid after reset", 32'(out_valid), 0);
    idle(20);

    // R1 R4 R9: plain 8-bit frame
    send_frame(8'hA5, 2'd3, 0, 0, 0, 1, 0, -1, -1, "R1");
    idle(4);
    // R4: 5 bits, upper bits dropped
    send_frame(8'hF3, 2'd0, 0, 0, 0, 1, 0, -1, -1, "R4");
    idle(4);
    // R4 R5: 6 bits, odd parity
    send_frame(8'h3F, 2'd1, 1, 1, 0, 1, 0, -1, -1, "R4");
    idle(4);
    // R5: even and odd parity, good and bad
    send_frame(8'h5A, 2'd2, 1, 0, 0, 1, 0, -1, -1, "R5");
    idle(4);
    send_frame(8'h5A, 2'd2, 1, 1, 0, 1, 0, -1, -1, "R5");
    idle(4);
    send_frame(8'h37, 2'd3, 1, 0, 0, 1, 1, -1, -1, "R5");
    idle(4);
    send_frame(8'h37, 2'd3, 1, 1, 0, 1, 1, -1, -1, "R5");
    idle(4);
    // R2: single corrupted tick on each of the three sample points
    send_frame(8'h0F, 2'd3, 0, 0, 0, 1, 0, 4, 8, "R2");
    idle(4);
    send_frame(8'hF0, 2'd3, 0, 0, 0, 1, 0, 2, 7, "R2");
    idle(4);
    send_frame(8'h96, 2'd3, 1, 0, 0, 1, 0, 0, 9, "R2");
    idle(4);

    // R3: start pulse too short
    s = seen;
    for (int i = 0; i < 6; i++) send_tick(1'b0);
    idle(40);
    chk(seen == s, "R3", "entries after false start", 32'(seen - s), 0);
    send_frame(8'hC3, 2'd3, 0, 0, 0, 1, 0, -1, -1, "R3");
    idle(4);

    // R8: transition code, with and without parity
    send_frame(8'h4B, 2'd3, 1, 0, 1, 1, 0, -1, -1, "R8");
    idle(4);
    send_frame(8'h1D, 2'd1, 0, 0, 1, 1, 0, -1, -1, "R8");
    idle(4);

    // R6: framing error
    send_frame(8'h81, 2'd3, 0, 0, 0, 0, 0, -1, -1, "R6");
    idle(20);
    // R7 then R10: break, line held low must not restart
    s = seen;
    send_frame(8'h00, 2'd3, 1, 0, 0, 0, 0, -1, -1, "R7");
    for (int i = 0; i < 40; i++) send_tick(1'b0);
    idle(20);
    chk(seen == s + 1, "R10", "entries after held-low break", 32'(seen - s), 1);
    // R10: back-to-back frames with one stop bit
    send_frame(8'h12, 2'd3, 0, 0, 0, 1, 0, -1, -1, "R10");
    send_frame(8'hED, 2'd3, 0, 0, 0, 1, 0, -1, -1, "R10");
    idle(20);

    chk(exp_q.size() == 0, "R9", "pending entries", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule